// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block turns one asynchronous external interrupt pin into a clean, single-cycle interrupt request. The pin is brought into the clock domain through a two-stage synchronizer. A sampling noise filter then changes its output only after three consecutive samples agree on the new level. A configurable edge of that filtered signal raises a one-cycle request pulse, which is meant for a downstream interrupt latch.

An 8-bit control register selects the edge condition and the filter sampling interval, and it reports the filtered level captured when the last request fired. The `slow_mode_i` input tells the block that `clk_i` is the low-frequency clock. In that mode the sampling interval is fixed at every 4 clocks, whatever the interval field holds. When the interval field or the mode changes, the sample counter restarts and the filtered level is held, so the reconfiguration itself never produces a request.

Top module: `ext_irq_filter`

## Requirements
- R1: After reset, `rd_data_o` reads 8'h00 and `irq_o` is 0.
- R2: Bits 7:5 of `rd_data_o` always read 0. A write stores only bits 4:3 and 1:0, so writing 8'hFF reads back as 8'h1B while the status bit is 0.
- R3: The edge field is bits 4:3. Code 00 requests on a rising edge of the filtered level, code 01 on a falling edge and code 10 on both edges. An edge of the other polarity raises no request.
- R4: Edge code 11 never raises a request, whatever the pin does.
- R5: The filtered level changes only after three consecutive samples agree on the new level. In fast mode with interval code 00, a pin pulse lasting 2 clocks raises no request. With interval code 11, a pulse lasting 20 clocks raises no request.
- R6: The interval field is bits 1:0. In fast mode, codes 00, 01, 10 and 11 give a sample every 1, 4, 8 and 16 clocks (P). After a pin change driven before clock edge 1, the request is visible after edge L, where 4+2P <= L <= 3+3P. For P=1, L is exactly 6.
- R7: While `slow_mode_i` is 1, the sample period is 4 clocks for every interval code, so 12 <= L <= 15.
- R8: Each qualifying edge gives exactly one `irq_o` pulse, one clock wide.
- R9: Bit 2 reads the filtered level captured in the same clock as the request: 1 for high and 0 for low. It does not change between requests.
- R10: A change of the interval field or of `slow_mode_i` restarts the sample counter and holds the filtered level, so the change raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (the gear clock in fast mode, the low-frequency clock in slow mode) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| slow_mode_i | input | 1 | 1 selects the slow or sleep operating mode |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions assume that software does not rewrite the edge field in the same clock as a request pulse, because the status checks relate the request to the previous clock's edge code. They also assume that `pin_i` and `slow_mode_i` change no faster than once per clock. The stimulus drives every input on the falling clock edge. It changes the edge or interval fields only while the pin has been steady for long enough that no filtered edge is pending. It waits out a full filter window after each reconfiguration before it moves the pin.

// File: rtl/irq_filt_pkg.sv
package irq_filt_pkg;
  localparam int unsigned CTRL_W = 8;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sample_timer.sv
module irq_sample_timer #(
  parameter int unsigned FAST_MAX_LOG2 = 4,
  parameter int unsigned SLOW_DIV      = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       slow_i,
  input  logic [1:0] ival_i,
  output logic       tick_o
);
  localparam int unsigned CNT_W = FAST_MAX_LOG2;

  logic [CNT_W-1:0] cnt_q, lim;

  // code 0 -> every clock, code n -> every 2^(n+1) clocks
  always_comb begin
    if (slow_i)              lim = CNT_W'(SLOW_DIV - 1);
    else if (ival_i == 2'd0) lim = '0;
    else                     lim = CNT_W'((32'd1 << (32'(ival_i) + 32'd1)) - 32'd1);
  end

  assign tick_o = !restart_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_noise_filter.sv
module irq_noise_filter #(
  parameter int unsigned AGREE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(AGREE);

  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (restart_i) begin
      run_q <= '0;
    end else if (tick_i) begin
      if (sample_i == level_q) begin
        run_q <= '0;
      end else if (run_q == CW'(AGREE - 1)) begin
        run_q   <= '0;
        level_q <= sample_i;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter
  import irq_filt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned AGREE         = 3,
  parameter int unsigned FAST_MAX_LOG2 = 4,
  parameter int unsigned SLOW_DIV      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              slow_mode_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              irq_o
);
  edge_sel_e  edge_q;
  logic [1:0] ival_q;
  logic       lvl_q;
  logic [2:0] sel_q;
  logic       restart, sample_en, pin_s, filt_lvl, filt_d, hit, irq_q;
  logic       unused_wr;

  assign unused_wr = ^{wr_data_i[7:5], wr_data_i[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= EDGE_RISE;
      ival_q <= '0;
    end else if (wr_en_i) begin
      edge_q <= edge_sel_e'(wr_data_i[4:3]);
      ival_q <= wr_data_i[1:0];
    end
  end

  // any change of rate selection restarts sampling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= {slow_mode_i, ival_q};
  end
  assign restart = ({slow_mode_i, ival_q} != sel_q);

  irq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  irq_sample_timer #(
    .FAST_MAX_LOG2(FAST_MAX_LOG2),
    .SLOW_DIV     (SLOW_DIV)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .slow_i   (slow_mode_i),
    .ival_i   (ival_q),
    .tick_o   (sample_en)
  );

  irq_noise_filter #(.AGREE(AGREE)) i_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (pin_s),
    .tick_i   (sample_en),
    .restart_i(restart),
    .level_o  (filt_lvl)
  );

  always_comb begin
    unique case (edge_q)
      EDGE_RISE: hit = filt_lvl && !filt_d;
      EDGE_FALL: hit = !filt_lvl && filt_d;
      EDGE_BOTH: hit = filt_lvl != filt_d;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_d <= 1'b0;
      irq_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      filt_d <= filt_lvl;
      irq_q  <= hit;
      if (hit) lvl_q <= filt_lvl;
    end
  end

  assign irq_o     = irq_q;
  assign rd_data_o = {3'b000, edge_q, lvl_q, ival_q};
endmodule

// File: rtl/ext_irq_filter_chk.sv
module ext_irq_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic       restart,
  input logic       sample_en,
  input logic       filt_lvl
);
  p_hi_bits_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:5] == 3'b000);

  p_rise_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(rd_data_o[4:3]) == 2'b00) |-> rd_data_o[2]);

  p_fall_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(rd_data_o[4:3]) == 2'b01) |-> !rd_data_o[2]);

  p_reserved_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_data_o[4:3]) == 2'b11) |-> !irq_o);

  p_filter_on_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_lvl) |-> $past(sample_en));

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_status_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> $stable(rd_data_o[2]));

  p_restart_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> $stable(filt_lvl));
endmodule

bind ext_irq_filter ext_irq_filter_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o),
  .restart  (restart),
  .sample_en(sample_en),
  .filt_lvl (filt_lvl)
);

// File: tb/test_ext_irq_filter.sv
`timescale 1ns/1ps
module test_ext_irq_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b0;
  logic       slow_mode_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  ext_irq_filter i_ext_irq_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .slow_mode_i(slow_mode_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .irq_o      (irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // drive pin, return clock edges until irq seen (0 if none within maxc)
  task automatic drive_and_wait(input logic v, input int maxc, output int lat);
    @(negedge clk_i);
    pin_i = v;
    lat = 0;
    for (int n = 1; n <= maxc; n++) begin
      @(posedge clk_i); #1;
      if (irq_o) begin lat = n; break; end
    end
  endtask

  task automatic count_irq(input int cycles, output int cnt);
    cnt = 0;
    for (int n = 0; n < cycles; n++) begin
      @(posedge clk_i); #1;
      if (irq_o) cnt++;
    end
  endtask

  task automatic t_reset();
    #1;
    check(rd_data_o == 8'h00, "R1 reg", rd_data_o, 0);
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
  endtask

  task automatic t_regs();
    write_ctrl(8'hFF); #1;
    check(rd_data_o == 8'h1B, "R2 masked write", rd_data_o, 8'h1B);
    write_ctrl(8'h00);
    repeat (10) @(negedge clk_i);
  endtask

  task automatic t_rise();
    int lat, cnt;
    drive_and_wait(1'b1, 30, lat);
    check(lat == 6, "R6 latency P1", lat, 6);
    check(rd_data_o[2] == 1'b1, "R9 status high", rd_data_o[2], 1);
    @(posedge clk_i); #1;
    check(irq_o == 1'b0, "R8 one-cycle pulse", irq_o, 0);
    drive_and_wait(1'b0, 20, lat);
    check(lat == 0, "R3 rise ignores fall", lat, 0);
    check(rd_data_o[2] == 1'b1, "R9 status held", rd_data_o[2], 1);
  endtask

  task automatic t_fall();
    int lat;
    write_ctrl(8'h08);
    drive_and_wait(1'b1, 20, lat);
    check(lat == 0, "R3 fall ignores rise", lat, 0);
    drive_and_wait(1'b0, 30, lat);
    check(lat == 6, "R3 falling edge", lat, 6);
    check(rd_data_o[2] == 1'b0, "R9 status low", rd_data_o[2], 0);
  endtask

  task automatic t_both();
    int lat, cnt;
    write_ctrl(8'h10);
    drive_and_wait(1'b1, 30, lat);
    check(lat == 6, "R3 both rise", lat, 6);
    count_irq(15, cnt);
    check(cnt == 0, "R8 no extra pulse", cnt, 0);
    drive_and_wait(1'b0, 30, lat);
    check(lat == 6, "R3 both fall", lat, 6);
  endtask

  task automatic t_reserved();
    int lat;
    write_ctrl(8'h18);
    drive_and_wait(1'b1, 30, lat);
    check(lat == 0, "R4 reserved rise", lat, 0);
    drive_and_wait(1'b0, 30, lat);
    check(lat == 0, "R4 reserved fall", lat, 0);
  endtask

  task automatic t_glitch();
    int cnt;
    write_ctrl(8'h10);
    @(negedge clk_i); pin_i = 1'b1;
    repeat (2) @(negedge clk_i);
    pin_i = 1'b0;
    count_irq(30, cnt);
    check(cnt == 0, "R5 glitch P1", cnt, 0);
    write_ctrl(8'h13);
    repeat (60) @(negedge clk_i);
    pin_i = 1'b1;
    repeat (20) @(negedge clk_i);
    pin_i = 1'b0;
    count_irq(80, cnt);
    check(cnt == 0, "R5 glitch P16", cnt, 0);
  endtask

  task automatic t_intervals();
    int lat, p;
    logic lv;
    lv = 1'b0;
    for (int c = 1; c <= 3; c++) begin
      p = 1 << (c + 1);
      write_ctrl(8'h10 | 8'(c));
      repeat (60) @(negedge clk_i);
      lv = ~lv;
      drive_and_wait(lv, 100, lat);
      check(lat >= 4 + 2 * p && lat <= 3 + 3 * p, "R6 interval latency", lat, 3 * p);
    end
    if (lv) begin
      drive_and_wait(1'b0, 100, lat);
      check(lat != 0, "R6 return low", lat, 1);
    end
  endtask

  task automatic t_slow();
    int lat;
    @(negedge clk_i); slow_mode_i = 1'b1;
    write_ctrl(8'h10);
    repeat (30) @(negedge clk_i);
    drive_and_wait(1'b1, 60, lat);
    check(lat >= 12 && lat <= 15, "R7 slow code 0", lat, 12);
    write_ctrl(8'h13);
    repeat (30) @(negedge clk_i);
    drive_and_wait(1'b0, 60, lat);
    check(lat >= 12 && lat <= 15, "R7 slow code 3", lat, 12);
    @(negedge clk_i); slow_mode_i = 1'b0;
    repeat (30) @(negedge clk_i);
  endtask

  task automatic t_restart();
    int lat, cnt;
    write_ctrl(8'h10);
    repeat (10) @(negedge clk_i);
    drive_and_wait(1'b1, 30, lat);
    check(lat == 6, "R10 setup high", lat, 6);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      int c;
      @(negedge clk_i); slow_mode_i = ~slow_mode_i;
      count_irq(3, c); cnt += c;
      write_ctrl(8'h10 | 8'(k % 4));
      count_irq(5, c); cnt += c;
    end
    check(cnt == 0, "R10 no spurious irq", cnt, 0);
    check(rd_data_o[2] == 1'b1, "R10 level held", rd_data_o[2], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_regs();
    t_rise();
    t_fall();
    t_both();
    t_reserved();
    t_glitch();
    t_intervals();
    t_slow();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule